// File: doc/BRIEF.md
# DDR Mode Register Load Controller

This block models the command side of a DDR memory device's mode-register programming. A load command carries a two-bit bank-select value and an address word. Bank-select 00 targets the base mode register, which holds burst length, burst ordering, CAS latency and the operating-mode field. Bank-select 01 targets the extended register, which holds the DLL disable bit and the drive-strength bit. The stored contents are decoded continuously onto plain outputs, so a controller or a model downstream can read the current configuration with no further decoding.

Each load is checked before it is accepted. A load that arrives while any bank is open or a burst is running is refused. A load that carries a reserved field code, or a bank-select pattern with the upper bit set, is also refused. A command that lands inside the post-load wait window is dropped. After a load that turns the DLL on, the next accepted load must be a base load that requests a DLL reset. Each kind of violation sets its own sticky flag. Only the reset input, which stands for power loss, clears the registers and the flags.

Top module: `ddr_mode_load_ctl`

## Requirements
- R1: An accepted load with `ba`=00 writes the base register and one with `ba`=01 writes the extended register. The decoded outputs show the new value in the cycle after the command edge, and the other register keeps its value.
- R2: Base address bits 2:0 set `burst_len`: code 001 gives 2, 010 gives 4 and 011 gives 8, whatever the value of bit 3. Every other code is reserved.
- R3: Base address bit 3 drives `burst_ilv`: 0 is sequential ordering and 1 is interleaved ordering.
- R4: Base address bits 6:4 set `cas_x2`, the CAS latency in half cycles: code 010 gives 4 (latency 2) and code 110 gives 5 (latency 2.5). Every other code is reserved.
- R5: In a base load, bits 12:7 equal to 000000 mean normal operation and give `dll_reset`=0. A value with only bit 8 set means normal operation with DLL reset and gives `dll_reset`=1. Any other value is reserved.
- R6: In an extended load, bit 0 is DLL disable (`dll_enable` = NOT bit 0) and bit 1 drives `drive_reduced`. Bits 12:2 must be zero; any other value is reserved.
- R7: A load with a reserved code, or with `ba`[1]=1, changes neither register and sets the sticky flag `err_rsvd`.
- R8: A load while `banks_idle`=0 or `burst_active`=1 changes neither register, does not start the wait window, and sets the sticky flag `err_state`.
- R9: An accepted load raises `busy` for the 2 cycles that follow its edge. Any `cmd_valid` sampled while `busy`=1, whether it is a load or not, is dropped and sets the sticky flag `err_timing`.
- R10: After an accepted extended load with bit 0 = 0, the next accepted load must be a base load with bit 8 = 1. Any other accepted load sets the sticky flag `err_dll` and is still written.
- R11: Reset clears both registers. Afterwards `burst_len`=0, `burst_ilv`=0, `cas_x2`=0, `dll_reset`=0, `dll_enable`=1, `drive_reduced`=0, `busy`=0, and all four error flags are 0.
- R12: Error flags stay set through later legal loads and clear only on reset. A command with `cmd_load`=0 outside the wait window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; models power loss |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_load | input | 1 | The command is a mode-register load |
| ba | input | 2 | Bank select; picks the target register |
| addr | input | ADDR_W | Address word carrying the register value |
| banks_idle | input | 1 | All banks are precharged |
| burst_active | input | 1 | A read or write burst is running |
| busy | output | 1 | Post-load wait window is open |
| burst_len | output | 4 | Decoded burst length (0 when reserved or after reset) |
| burst_ilv | output | 1 | Interleaved burst ordering selected |
| cas_x2 | output | 3 | CAS latency in half cycles |
| dll_reset | output | 1 | Stored operating mode requests a DLL reset |
| dll_enable | output | 1 | DLL is enabled according to the extended register |
| drive_reduced | output | 1 | Reduced output drive strength is selected |
| err_state | output | 1 | Sticky: load refused because of the bank or burst state |
| err_rsvd | output | 1 | Sticky: reserved code or bank-select pattern |
| err_timing | output | 1 | Sticky: command arrived inside the wait window |
| err_dll | output | 1 | Sticky: the DLL enable was not followed by a DLL reset |

## Verification
The hardest case to reach is the DLL sequence rule. It needs an extended load that enables the DLL, followed by a second accepted load. That second load must fall outside the wait window, or it is dropped for timing and never tested against the rule. The stimulus resets the block between scenarios, then issues the enabling extended load. Once `busy` has dropped, it follows with a base load without DLL reset in one case, with DLL reset in another, and with a second extended load in a third. A separate test sends a command on the cycle right after an accepted load. This shows that a dropped command affects neither register.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

   localparam int MR_FIELD_W = 13;

   localparam logic [2:0] BL_CODE_2  = 3'b001;
   localparam logic [2:0] BL_CODE_4  = 3'b010;
   localparam logic [2:0] BL_CODE_8  = 3'b011;

   localparam logic [2:0] CL_CODE_20 = 3'b010;
   localparam logic [2:0] CL_CODE_25 = 3'b110;

   localparam logic [5:0] OP_NORMAL  = 6'b000000;
   localparam logic [5:0] OP_DLL_RST = 6'b000010;

   localparam logic [1:0] SEL_BASE   = 2'b00;
   localparam logic [1:0] SEL_EXT    = 2'b01;

   typedef enum logic {
      BT_SEQ = 1'b0,
      BT_ILV = 1'b1
   } burst_type_e;

   typedef struct packed {
      logic [3:0]  len;
      burst_type_e btype;
      logic [2:0]  cas_x2;
      logic        dll_rst;
   } base_dec_t;

endpackage

// File: rtl/mrs_field_check.sv
module mrs_field_check
   import ddr_mrs_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              base_ok,
   output logic              ext_ok
);

   logic upper_zero;
   logic len_ok;
   logic cas_ok;
   logic op_ok;

   generate
      if (ADDR_W > MR_FIELD_W) begin : g_wide
         assign upper_zero = ~|addr[ADDR_W-1:MR_FIELD_W];
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (addr[2:0])
         BL_CODE_2, BL_CODE_4, BL_CODE_8: len_ok = 1'b1;
         default:                         len_ok = 1'b0;
      endcase
      unique case (addr[6:4])
         CL_CODE_20, CL_CODE_25: cas_ok = 1'b1;
         default:                cas_ok = 1'b0;
      endcase
      op_ok = (addr[12:7] == OP_NORMAL) || (addr[12:7] == OP_DLL_RST);
   end

   assign base_ok = upper_zero & len_ok & cas_ok & op_ok;
   assign ext_ok  = upper_zero & ~|addr[12:2];

   always_comb begin
      a_r6_ext_excl_high: assert (!(ext_ok && |addr[12:2]))
         else $error("extended load accepted with upper bits set");
   end

endmodule

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
   parameter int WAIT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES + 1) : 1;

   generate
      if (WAIT_CYCLES < 1) begin : g_bad_wait
         $error("mrs_wait_timer: WAIT_CYCLES must be at least 1");
      end

      if (WAIT_CYCLES == 1) begin : g_single
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= start;
         end
         assign busy = hold_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (start)          cnt_q <= CW'(WAIT_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);
      end
   endgenerate

   a_r9_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy)
      else $error("wait window did not open after a load");

   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start)
      else $error("load accepted inside the wait window");

endmodule

// File: rtl/mrs_reg_file.sv
module mrs_reg_file
   import ddr_mrs_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_base,
   input  logic                  wr_ext,
   input  logic [MR_FIELD_W-1:0] din,
   output logic [MR_FIELD_W-1:0] base_q,
   output logic [1:0]            ext_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_base) begin
         base_q <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= '0;
      end else if (wr_ext) begin
         ext_q <= din[1:0];
      end
   end

   a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_base && wr_ext))
      else $error("both registers written at once");

   a_r7_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_base |=> $stable(base_q))
      else $error("base register changed without a write");

   a_r7_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ext |=> $stable(ext_q))
      else $error("extended register changed without a write");

endmodule

// File: rtl/mrs_decode.sv
module mrs_decode
   import ddr_mrs_pkg::*;
(
   input  logic [MR_FIELD_W-1:0] base_q,
   output base_dec_t             dec
);

   always_comb begin
      dec = '0;
      unique case (base_q[2:0])
         BL_CODE_2: dec.len = 4'd2;
         BL_CODE_4: dec.len = 4'd4;
         BL_CODE_8: dec.len = 4'd8;
         default:   dec.len = 4'd0;
      endcase
      dec.btype = base_q[3] ? BT_ILV : BT_SEQ;
      unique case (base_q[6:4])
         CL_CODE_20: dec.cas_x2 = 3'd4;
         CL_CODE_25: dec.cas_x2 = 3'd5;
         default:    dec.cas_x2 = 3'd0;
      endcase
      dec.dll_rst = (base_q[12:7] == OP_DLL_RST);
   end

   always_comb begin
      a_r2_len_values: assert (dec.len inside {4'd0, 4'd2, 4'd4, 4'd8})
         else $error("burst length outside the legal set");
      a_r4_cas_values: assert (dec.cas_x2 inside {3'd0, 3'd4, 3'd5})
         else $error("CAS latency outside the legal set");
   end

endmodule

// File: rtl/ddr_mode_load_ctl.sv
module ddr_mode_load_ctl
   import ddr_mrs_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int WAIT_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_load,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   input  logic              banks_idle,
   input  logic              burst_active,
   output logic              busy,
   output logic [3:0]        burst_len,
   output logic              burst_ilv,
   output logic [2:0]        cas_x2,
   output logic              dll_reset,
   output logic              dll_enable,
   output logic              drive_reduced,
   output logic              err_state,
   output logic              err_rsvd,
   output logic              err_timing,
   output logic              err_dll
);

   generate
      if (ADDR_W < MR_FIELD_W) begin : g_bad_addr
         $error("ddr_mode_load_ctl: ADDR_W must cover the 13-bit register field");
      end
   endgenerate

   logic                  base_ok;
   logic                  ext_ok;
   logic                  take;
   logic                  is_load;
   logic                  state_bad;
   logic                  sel_base;
   logic                  sel_ext;
   logic                  wr_base;
   logic                  wr_ext;
   logic                  rsvd_hit;
   logic                  dll_hit;
   logic                  dll_pend_q;
   logic [MR_FIELD_W-1:0] base_q;
   logic [1:0]            ext_q;
   base_dec_t             dec;

   mrs_field_check #(.ADDR_W(ADDR_W)) chk_i (
      .addr    (addr),
      .base_ok (base_ok),
      .ext_ok  (ext_ok)
   );

   always_comb begin
      take      = cmd_valid & ~busy;
      is_load   = take & cmd_load;
      state_bad = is_load & (~banks_idle | burst_active);
      sel_base  = (ba == SEL_BASE);
      sel_ext   = (ba == SEL_EXT);
      wr_base   = is_load & ~state_bad & sel_base & base_ok;
      wr_ext    = is_load & ~state_bad & sel_ext & ext_ok;
      rsvd_hit  = is_load & ~state_bad &
                  (ba[1] | (sel_base & ~base_ok) | (sel_ext & ~ext_ok));
      dll_hit   = dll_pend_q & (wr_ext | (wr_base & ~addr[8]));
   end

   mrs_reg_file regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_base (wr_base),
      .wr_ext  (wr_ext),
      .din     (addr[MR_FIELD_W-1:0]),
      .base_q  (base_q),
      .ext_q   (ext_q)
   );

   mrs_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_base | wr_ext),
      .busy  (busy)
   );

   mrs_decode dec_i (
      .base_q (base_q),
      .dec    (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dll_pend_q <= 1'b0;
      end else if (wr_ext) begin
         dll_pend_q <= ~addr[0];
      end else if (wr_base) begin
         dll_pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_state  <= 1'b0;
         err_rsvd   <= 1'b0;
         err_timing <= 1'b0;
         err_dll    <= 1'b0;
      end else begin
         err_state  <= err_state  | state_bad;
         err_rsvd   <= err_rsvd   | rsvd_hit;
         err_timing <= err_timing | (cmd_valid & busy);
         err_dll    <= err_dll    | dll_hit;
      end
   end

   assign burst_len     = dec.len;
   assign burst_ilv     = (dec.btype == BT_ILV);
   assign cas_x2        = dec.cas_x2;
   assign dll_reset     = dec.dll_rst;
   assign dll_enable    = ~ext_q[0];
   assign drive_reduced = ext_q[1];

   a_r8_state_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_load && !busy && (!banks_idle || burst_active))
         |=> (!busy && err_state))
      else $error("load accepted while banks were not idle");

   a_r7_ba1_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && ba[1]) |=> ($stable(burst_len) && $stable(cas_x2) &&
                                $stable(dll_enable) && $stable(drive_reduced)))
      else $error("upper bank-select bit changed a register");

   a_r9_late_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy) |=> err_timing)
      else $error("command inside wait window not flagged");

   a_r12_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (err_state || err_rsvd || err_timing || err_dll) |=>
         ($past(err_state) <= err_state && $past(err_rsvd) <= err_rsvd &&
          $past(err_timing) <= err_timing && $past(err_dll) <= err_dll))
      else $error("sticky flag cleared without reset");

   a_r10_pend_base_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (dll_pend_q && wr_base && addr[8]) |=> (!dll_pend_q && $stable(err_dll)))
      else $error("proper DLL reset load was flagged");

endmodule

// File: tb/ddr_mode_load_ctl_tb_top.sv
module ddr_mode_load_ctl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 13;
   localparam int NVEC       = 14;

   typedef struct packed {
      logic [1:0]  ba;
      logic [12:0] addr;
      logic        acc;
      logic [3:0]  bl;
      logic        ilv;
      logic [2:0]  cas;
      logic        rst;
      logic        en;
      logic        drv;
   } vec_t;

   // Walked in order: expected values are the outputs after each command.
   localparam vec_t TBL [NVEC] = '{
      '{2'b00, 13'h021, 1'b1, 4'd2, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0},
      '{2'b00, 13'h06A, 1'b1, 4'd4, 1'b1, 3'd5, 1'b0, 1'b1, 1'b0},
      '{2'b00, 13'h123, 1'b1, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b00, 13'h020, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b00, 13'h024, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b00, 13'h032, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b00, 13'h0A2, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b10, 13'h021, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b11, 13'h003, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
      '{2'b01, 13'h003, 1'b1, 4'd8, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1},
      '{2'b01, 13'h007, 1'b0, 4'd8, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1},
      '{2'b00, 13'h06B, 1'b1, 4'd8, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1},
      '{2'b01, 13'h001, 1'b1, 4'd8, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0},
      '{2'b00, 13'h06E, 1'b0, 4'd8, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_load = 1'b0;
   logic [1:0]        ba = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              banks_idle = 1'b1;
   logic              burst_active = 1'b0;
   logic              busy;
   logic [3:0]        burst_len;
   logic              burst_ilv;
   logic [2:0]        cas_x2;
   logic              dll_reset;
   logic              dll_enable;
   logic              drive_reduced;
   logic              err_state;
   logic              err_rsvd;
   logic              err_timing;
   logic              err_dll;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ddr_mode_load_ctl #(.ADDR_W(ADDR_W), .WAIT_CYCLES(2)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_load      (cmd_load),
      .ba            (ba),
      .addr          (addr),
      .banks_idle    (banks_idle),
      .burst_active  (burst_active),
      .busy          (busy),
      .burst_len     (burst_len),
      .burst_ilv     (burst_ilv),
      .cas_x2        (cas_x2),
      .dll_reset     (dll_reset),
      .dll_enable    (dll_enable),
      .drive_reduced (drive_reduced),
      .err_state     (err_state),
      .err_rsvd      (err_rsvd),
      .err_timing    (err_timing),
      .err_dll       (err_dll)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Present a command for one edge starting at the current negedge.
   task automatic drive(input logic ld, input logic [1:0] b, input logic [12:0] a);
      cmd_valid = 1'b1;
      cmd_load  = ld;
      ba        = b;
      addr      = a;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_load  = 1'b0;
   endtask

   task automatic issue(input logic [1:0] b, input logic [12:0] a);
      @(negedge clk);
      drive(1'b1, b, a);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      do_reset();

      // R11 reset state
      check("R11 burst_len", burst_len, 0);
      check("R11 cas_x2", cas_x2, 0);
      check("R11 dll_enable", dll_enable, 1);
      check("R11 drive_reduced", drive_reduced, 0);
      check("R11 dll_reset", dll_reset, 0);
      check("R11 busy", busy, 0);
      check("R11 flags", {err_state, err_rsvd, err_timing, err_dll}, 0);

      // R1 R2 R3 R4 R5 R6 R7: table walk
      for (int i = 0; i < NVEC; i++) begin
         issue(TBL[i].ba, TBL[i].addr);
         check($sformatf("R1 R7 v%0d accepted", i), busy, TBL[i].acc);
         check($sformatf("R2 v%0d burst_len", i), burst_len, TBL[i].bl);
         check($sformatf("R3 v%0d burst_ilv", i), burst_ilv, TBL[i].ilv);
         check($sformatf("R4 v%0d cas_x2", i), cas_x2, TBL[i].cas);
         check($sformatf("R5 v%0d dll_reset", i), dll_reset, TBL[i].rst);
         check($sformatf("R6 v%0d dll_enable", i), dll_enable, TBL[i].en);
         check($sformatf("R6 v%0d drive_reduced", i), drive_reduced, TBL[i].drv);
         settle();
      end
      check("R7 err_rsvd set", err_rsvd, 1);
      check("R12 err_rsvd kept after legal loads", err_rsvd, 1);
      check("R8 err_state clear", err_state, 0);
      check("R9 err_timing clear", err_timing, 0);
      check("R10 err_dll clear", err_dll, 0);

      // R8 banks not idle, then burst active
      banks_idle = 1'b0;
      issue(2'b00, 13'h123);
      check("R8 no busy", busy, 0);
      check("R8 burst_len kept", burst_len, 8);
      check("R8 cas kept", cas_x2, 5);
      check("R8 err_state", err_state, 1);
      banks_idle = 1'b1;
      burst_active = 1'b1;
      issue(2'b00, 13'h021);
      check("R8 burst active refused", burst_len, 8);
      check("R8 burst active no busy", busy, 0);
      burst_active = 1'b0;
      settle();

      // R9 command right after an accepted load
      issue(2'b00, 13'h021);
      check("R9 busy after load", busy, 1);
      check("R9 first load applied", burst_len, 2);
      drive(1'b1, 2'b00, 13'h06A);
      check("R9 err_timing", err_timing, 1);
      check("R9 dropped load", burst_len, 2);
      check("R9 dropped load ilv", burst_ilv, 0);
      check("R9 still busy", busy, 1);
      @(negedge clk);
      check("R9 window closed", busy, 0);

      // R12 non-load command outside the window
      issue(2'b00, 13'h06A);
      cmd_load = 1'b0;
      check("R12 nonload busy", busy, 1);
      settle();
      @(negedge clk);
      drive(1'b0, 2'b00, 13'h021);
      check("R12 nonload no change", burst_len, 4);
      check("R12 nonload no busy", busy, 0);
      check("R12 err_timing kept", err_timing, 1);

      // R11 reset clears everything again
      do_reset();
      check("R11 re-reset len", burst_len, 0);
      check("R11 re-reset flags", {err_state, err_rsvd, err_timing, err_dll}, 0);
      check("R11 re-reset drive", drive_reduced, 0);

      // R10 enable DLL, then base load without reset
      issue(2'b01, 13'h000);
      check("R10 ext accepted", busy, 1);
      check("R10 dll_enable", dll_enable, 1);
      settle();
      issue(2'b00, 13'h021);
      check("R10 missed reset flagged", err_dll, 1);
      check("R10 violating load written", burst_len, 2);
      settle();
      issue(2'b00, 13'h06A);
      check("R12 err_dll sticky", err_dll, 1);

      // R10 enable DLL, then proper reset
      do_reset();
      issue(2'b01, 13'h000);
      settle();
      issue(2'b00, 13'h121);
      check("R10 proper reset not flagged", err_dll, 0);
      check("R5 dll_reset seen", dll_reset, 1);
      settle();

      // R10 enable DLL, then another extended load
      do_reset();
      issue(2'b01, 13'h000);
      settle();
      issue(2'b01, 13'h001);
      check("R10 ext after enable flagged", err_dll, 1);
      check("R10 ext written", dll_enable, 0);
      settle();

      summary();
   end

endmodule